// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is one performance-monitoring counter. A 32-bit type register chooses which event to count and decides, for each privilege level and security state, whether counting is allowed. The event number is 16 bits wide. It is matched against a parameterized list of supported numbers. Each list entry owns one line of the event input bus.

On every clock, the counter goes up by one when two things are true: the selected event line is high, and the filter allows counting in the current privilege level and security state. The filter is more than a plain enable. In the non-secure and realm states, a per-state override bit is compared against the base bit, and counting stops when the two differ.

Software writes the type register through a simple write port and reads it back unchanged, apart from the bits that are not implemented.

Top module: `priv_evt_counter`

## Requirements
- R1: After reset, the counter reads 0 and the type register reads 0.
- R2: A type register write stores only the implemented bits. These are bit 31 (priv base), bit 30 (user base), bit 29 (non-secure priv override), bit 28 (non-secure user override), bit 27 (level-2 allow), bit 21 (realm user override) and bits [15:0] (event number). All other bits, including bit 25, read back as 0. The new value is visible on the cycle after the write.
- R3: The event number in bits [15:0] selects the bus line whose index holds that number in the supported list. The default list maps 0x0003 to index 0, 0x0008 to 1, 0x0011 to 2 and 0x4001 to 3. An unlisted number counts nothing, yet it reads back exactly as written.
- R4: The counter adds 1 at each rising edge where the selected event is high and the filter allows counting. A new type value governs counting from the cycle after its write.
- R5: At level 0 in the secure state (sec_state 0 or 3), counting is blocked when and only when bit 30 is 1. Bit 31 has no effect at level 0.
- R6: At level 0 in the non-secure state (sec_state 1), counting is blocked when and only when bit 28 differs from bit 30.
- R7: At level 0 in the realm state (sec_state 2), counting is blocked when and only when bit 21 differs from bit 30.
- R8: At level 1, counting is blocked in the secure and realm states when bit 31 is 1. In the non-secure state it is blocked when bit 29 differs from bit 31.
- R9: At level 2, counting is blocked when bit 27 is 0.
- R10: At level 3, counting is blocked when bit 31 is 1 and top_narrow is 1. Otherwise level 3 counts.
- R11: The counter wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bus | input | N_EVENTS | One line per supported event, high in cycles where the event occurs |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| sec_state | input | 2 | Security state: 0 secure, 1 non-secure, 2 realm, 3 treated as secure |
| top_narrow | input | 1 | High when level 3 runs the 32-bit execution state |
| cfg_we | input | 1 | Type register write enable |
| cfg_wdata | input | 32 | Type register write data |
| cfg_rdata | output | 32 | Type register read-back |
| cnt_q | output | CNT_W | Counter value |

## Verification
The in-line assertions check the following on every cycle:
- the counter moves by at most one per cycle;
- a write lands masked on the next cycle;
- an unlisted event number freezes the counter;
- the secure level-0, non-secure level-1, level-2 and narrow level-3 blocking rules stop the counter.

Only the bench scenarios can show the rest:
- that each allowed combination really counts;
- that the correct bus line is the one selected;
- that the realm and non-secure level-0 override comparisons admit counting when the bits match;
- that the counter wraps. The wrap is shown on a narrow second instance.

// File: rtl/priv_evt_counter.sv
module priv_evt_counter #(
  parameter int N_EVENTS = 4,
  parameter int CNT_W = 32,
  parameter logic [N_EVENTS*16-1:0] EVT_IDS = {16'h4001, 16'h0011, 16'h0008, 16'h0003}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVENTS-1:0] evt_bus,
  input  logic [1:0]          cur_lvl,
  input  logic [1:0]          sec_state,
  input  logic                top_narrow,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [CNT_W-1:0]    cnt_q
);

  localparam logic [31:0] CFG_MASK = 32'hF820_FFFF;
  localparam logic [1:0] ST_NSEC  = 2'd1;
  localparam logic [1:0] ST_REALM = 2'd2;

  logic [31:0] cfg_q;
  logic [N_EVENTS-1:0] id_hit;
  logic allow;

  wire b_priv = cfg_q[31];
  wire b_user = cfg_q[30];
  wire o_nsk  = cfg_q[29];
  wire o_nsu  = cfg_q[28];
  wire l2_ok  = cfg_q[27];
  wire o_rlu  = cfg_q[21];

  for (genvar i = 0; i < N_EVENTS; i++) begin : g_match
    assign id_hit[i] = (cfg_q[15:0] == EVT_IDS[i*16 +: 16]);
  end

  wire evt_sel  = |(id_hit & evt_bus);
  wire count_en = evt_sel & allow;

  always_comb begin
    case (cur_lvl)
      2'd0: begin
        if (sec_state == ST_NSEC)       allow = (o_nsu == b_user);
        else if (sec_state == ST_REALM) allow = (o_rlu == b_user);
        else                            allow = !b_user;
      end
      2'd1: begin
        if (sec_state == ST_NSEC) allow = (o_nsk == b_priv);
        else                      allow = !b_priv;
      end
      2'd2:    allow = l2_ok;
      default: allow = !(b_priv && top_narrow);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata & CFG_MASK;
      if (count_en) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cfg_rdata = cfg_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_wr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_MASK)));

  assert_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|id_hit) |=> $stable(cnt_q));

  assert_sec_l0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd0 && sec_state != ST_NSEC && sec_state != ST_REALM && cfg_rdata[30])
      |=> $stable(cnt_q));

  assert_ns_l1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd1 && sec_state == ST_NSEC && cfg_rdata[29] != cfg_rdata[31])
      |=> $stable(cnt_q));

  assert_l2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd2 && !cfg_rdata[27]) |=> $stable(cnt_q));

  assert_l3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd3 && cfg_rdata[31] && top_narrow) |=> $stable(cnt_q));

endmodule

// File: tb/priv_evt_counter_tb_top.sv
module priv_evt_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] evt_bus = '0;
  logic [1:0] cur_lvl = '0;
  logic [1:0] sec_state = '0;
  logic top_narrow = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, w_rdata;
  logic [31:0] cnt_q;
  logic [3:0] w_cnt;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  priv_evt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .cur_lvl(cur_lvl),
    .sec_state(sec_state), .top_narrow(top_narrow), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cnt_q(cnt_q));

  priv_evt_counter #(.CNT_W(4)) wrap_i (
    .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .cur_lvl(cur_lvl),
    .sec_state(sec_state), .top_narrow(top_narrow), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(w_rdata), .cnt_q(w_cnt));

  // cfg, lvl, sec, narrow, bus, expected increment
  localparam int NV = 22;
  localparam logic [41:0] VEC [NV] = '{
    {32'h0000_0003, 2'd0, 2'd0, 1'b0, 4'b0001, 1'b1}, // R3 R5 idx0 counts
    {32'h0000_0003, 2'd0, 2'd0, 1'b0, 4'b1110, 1'b0}, // R3 other lines
    {32'h8000_0003, 2'd0, 2'd0, 1'b0, 4'b0001, 1'b1}, // R5 priv bit no effect
    {32'h4000_0003, 2'd0, 2'd0, 1'b0, 4'b0001, 1'b0}, // R5 user blocks
    {32'h4000_0003, 2'd0, 2'd1, 1'b0, 4'b0001, 1'b0}, // R6 mismatch
    {32'h5000_0003, 2'd0, 2'd1, 1'b0, 4'b0001, 1'b1}, // R6 match 1/1
    {32'h1000_0003, 2'd0, 2'd1, 1'b0, 4'b0001, 1'b0}, // R6 mismatch
    {32'h0000_0003, 2'd0, 2'd1, 1'b0, 4'b0001, 1'b1}, // R6 match 0/0
    {32'h4020_0003, 2'd0, 2'd2, 1'b0, 4'b0001, 1'b1}, // R7 match
    {32'h0020_0003, 2'd0, 2'd2, 1'b0, 4'b0001, 1'b0}, // R7 mismatch
    {32'h8000_0008, 2'd1, 2'd0, 1'b0, 4'b0010, 1'b0}, // R8 secure priv
    {32'h0000_0008, 2'd1, 2'd0, 1'b0, 4'b0010, 1'b1}, // R8 R3 idx1
    {32'hA000_0008, 2'd1, 2'd1, 1'b0, 4'b0010, 1'b1}, // R8 ns match
    {32'h2000_0008, 2'd1, 2'd1, 1'b0, 4'b0010, 1'b0}, // R8 ns mismatch
    {32'h8000_0008, 2'd1, 2'd2, 1'b0, 4'b0010, 1'b0}, // R8 realm priv
    {32'h0000_0011, 2'd2, 2'd1, 1'b0, 4'b0100, 1'b0}, // R9 not allowed
    {32'h0800_0011, 2'd2, 2'd1, 1'b0, 4'b0100, 1'b1}, // R9 allowed
    {32'h8000_4001, 2'd3, 2'd0, 1'b1, 4'b1000, 1'b0}, // R10 narrow blocks
    {32'h8000_4001, 2'd3, 2'd0, 1'b0, 4'b1000, 1'b1}, // R10 wide counts
    {32'h0000_4001, 2'd3, 2'd0, 1'b1, 4'b1000, 1'b1}, // R10 priv clear
    {32'h0000_0001, 2'd3, 2'd0, 1'b0, 4'b1111, 1'b0}, // R3 upper bits matter
    {32'h0800_0042, 2'd2, 2'd1, 1'b0, 4'b1111, 1'b0}  // R3 unlisted
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    chk("R1 cnt", cnt_q, 32'h0);
    chk("R1 cfg", cfg_rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][41:10]);
      cur_lvl = VEC[i][9:8];
      sec_state = VEC[i][7:6];
      top_narrow = VEC[i][5];
      evt_bus = VEC[i][4:1];
      c0 = cnt_q;
      @(negedge clk);
      evt_bus = '0;
      chk($sformatf("R4 vec%0d", i), cnt_q - c0, {31'h0, VEC[i][0]});
    end

    write_cfg(32'hFFFF_FFFF);
    chk("R2 mask", cfg_rdata, 32'hF820_FFFF);
    write_cfg(32'h0200_0000);
    chk("R2 bit25", cfg_rdata, 32'h0);
    write_cfg(32'h0000_0042);
    chk("R3 readback", cfg_rdata, 32'h0000_0042);

    // R4 multi-cycle and write timing
    cur_lvl = 2'd0; sec_state = 2'd0; top_narrow = 1'b0;
    write_cfg(32'h0000_0003);
    c0 = cnt_q;
    evt_bus = 4'b0001;
    repeat (5) @(negedge clk);
    chk("R4 five", cnt_q - c0, 32'd5);
    c0 = cnt_q;
    cfg_we = 1'b1; cfg_wdata = 32'h4000_0003;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R4 old cfg on write cycle", cnt_q - c0, 32'd1);
    c0 = cnt_q;
    @(negedge clk);
    chk("R4 new cfg next cycle", cnt_q - c0, 32'd0);

    // R11 wrap on the 4-bit instance
    write_cfg(32'h0000_0003);
    evt_bus = 4'b0001;
    for (int k = 0; k < 20; k++) begin
      if (w_cnt == 4'hF) break;
      @(negedge clk);
    end
    chk("R11 at max", {28'h0, w_cnt}, 32'hF);
    @(negedge clk);
    chk("R11 wrapped", {28'h0, w_cnt}, 32'h0);
    evt_bus = '0;

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset cnt", cnt_q, 32'h0);
    chk("R1 reset cfg", cfg_rdata, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule